// File: doc/BRIEF.md
# Column Inverse Transform with Pixel Store

This block runs the second, column pass of an 8x8 two-dimensional inverse cosine transform. It takes the eight 16-bit intermediate values of one column, left by a preceding row pass. It evaluates the full eight-point even/odd butterfly with fixed-point cosine weights scaled by 2^14. A rounding term of 2^19 is folded into the even sums, and each result is arithmetically shifted right by 20. No shortcut is taken for sparse or DC-only columns.

A two-bit mode picks how the eight results leave the block. Raw mode presents them in parallel as signed 16-bit values. Put mode clamps each result to an unsigned 8-bit pixel and writes it to memory. Add mode first reads a prediction pixel from memory, adds the result to it, and writes the clamped sum back to the same location.

Pixel k of the column lives at base + k*stride, where the stride is a runtime input. Reads and writes share one byte-wide memory port. That port uses a request/grant handshake, so the block can sit behind an arbiter. A one-cycle done pulse marks the end of each column.

Top module: `idctc_column`

## Requirements
- R1: While reset is high and in the first cycle after reset, mem_req and done are low.
- R2: With inputs x0..x7 and weights W1=22725, W2=21407, W3=19266, W4=16383, W5=12873, W6=8867, W7=4520, the block uses the following sums, with rnd = 2^19:
  - A0 = W4*x0 + W2*x2 + W4*x4 + W6*x6 + rnd
  - A1 = W4*x0 + W6*x2 - W4*x4 - W2*x6 + rnd
  - A2 = W4*x0 - W6*x2 - W4*x4 + W2*x6 + rnd
  - A3 = W4*x0 - W2*x2 + W4*x4 - W6*x6 + rnd
  - B0 = W1*x1 + W3*x3 + W5*x5 + W7*x7
  - B1 = W3*x1 - W7*x3 - W1*x5 - W5*x7
  - B2 = W5*x1 - W1*x3 + W7*x5 + W3*x7
  - B3 = W7*x1 - W5*x3 + W3*x5 - W1*x7

  For k = 0..3, y_k = (A_k + B_k) >>> 20 and y_(7-k) = (A_k - B_k) >>> 20. Input x_i is coef_i[16i+15:16i].
- R3: Raw mode is mode = 2'b00. The block makes no memory request, raises done in the third cycle after start is sampled, and holds y_k truncated to signed 16 bits in raw_res[16k+15:16k] while done is high.
- R4: Put mode is mode = 2'b01. The block makes eight writes, for k = 0..7 in ascending order, to address (base_addr + k*stride) mod 2^ADDR_W. Each write carries y_k clamped to 0..255.
- R5: Add mode is mode = 2'b10 or 2'b11. For each k in ascending order, the block reads address_k, then writes clamp(pred_k + y_k, 0..255) to the same address. Here pred_k is the byte read. The read of pixel k+1 follows the write of pixel k.
- R6: A request holds mem_addr, mem_we and mem_wdata unchanged until mem_gnt is high at a rising edge, which completes the transfer. Read data is taken from mem_rdata one cycle after the read grant.
- R7: In put and add modes, done is high for exactly one cycle, the cycle right after the grant of the eighth write.
- R8: A start while a column is in progress has no effect. A start in the cycle where done is high begins a new column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a column; samples mode, coef_i, base_addr, stride |
| mode | input | 2 | 00 raw, 01 put, 1x add |
| coef_i | input | 8*CW | Eight signed column inputs, input i at bits [16i+15:16i] |
| base_addr | input | ADDR_W | Byte address of pixel 0 |
| stride | input | ADDR_W | Address step between consecutive pixels |
| done | output | 1 | One-cycle end-of-column pulse |
| raw_res | output | 8*CW | Signed results y0..y7 |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | PIX_W | Write data |
| mem_gnt | input | 1 | Grant; completes the pending request at the edge |
| mem_rdata | input | PIX_W | Read data, valid the cycle after a read grant |

## Verification
Two pairs of events can share a cycle.
- **Grant and next request.** The grant of one pixel's write can coincide with presenting the next pixel's request. This is provoked by holding mem_gnt high throughout a put column, so that every cycle carries a transfer. The check is that each transfer matches the model's next expected address and byte.
- **Done and new start.** The done pulse can coincide with a start for the next column. The bench raises start in exactly the cycle done is seen. The new column's transfers must follow with the first column's outputs left intact.

Under a pseudo-random grant pattern, the model also requires that a withheld request stays unchanged. It also requires that a start arriving mid-column leaves the running column's traffic untouched.

// File: rtl/idctc_pkg.sv
`timescale 1ns/1ps
package idctc_pkg;
  localparam int NPT   = 8;
  localparam int IDX_W = $clog2(NPT);

  // cosine weights, cos(i*pi/16)*sqrt(2) scaled by 2^14
  localparam int K1 = 22725;
  localparam int K2 = 21407;
  localparam int K3 = 19266;
  localparam int K4 = 16383;
  localparam int K5 = 12873;
  localparam int K6 = 8867;
  localparam int K7 = 4520;

  localparam logic [1:0] MODE_RAW = 2'b00;
  localparam logic [1:0] MODE_PUT = 2'b01;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CALC,
    S_ISSUE,
    S_XFER,
    S_RWAIT
  } state_t;
endpackage

// File: rtl/idctc_core.sv
`timescale 1ns/1ps
module idctc_core #(
  parameter int CW    = 16,
  parameter int SHIFT = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic signed [CW-1:0] coef [idctc_pkg::NPT],
  output logic signed [CW-1:0] res  [idctc_pkg::NPT]
);
  import idctc_pkg::*;

  localparam int ACC_W = CW + 20;
  localparam int HALF  = NPT / 2;
  localparam logic signed [ACC_W-1:0] C1  = ACC_W'(K1);
  localparam logic signed [ACC_W-1:0] C2  = ACC_W'(K2);
  localparam logic signed [ACC_W-1:0] C3  = ACC_W'(K3);
  localparam logic signed [ACC_W-1:0] C4  = ACC_W'(K4);
  localparam logic signed [ACC_W-1:0] C5  = ACC_W'(K5);
  localparam logic signed [ACC_W-1:0] C6  = ACC_W'(K6);
  localparam logic signed [ACC_W-1:0] C7  = ACC_W'(K7);
  localparam logic signed [ACC_W-1:0] RND = ACC_W'(longint'(1) << (SHIFT - 1));

  logic signed [ACC_W-1:0] x    [NPT];
  logic signed [ACC_W-1:0] ev   [HALF];
  logic signed [ACC_W-1:0] od   [HALF];
  logic signed [CW-1:0]    lane [NPT];

  genvar gi;
  generate
    for (gi = 0; gi < NPT; gi++) begin : g_ext
      assign x[gi] = ACC_W'(coef[gi]);
    end
  endgenerate

  // even half carries the rounding term, odd half has none
  always_comb begin
    ev[0] = C4*x[0] + C2*x[2] + C4*x[4] + C6*x[6] + RND;
    ev[1] = C4*x[0] + C6*x[2] - C4*x[4] - C2*x[6] + RND;
    ev[2] = C4*x[0] - C6*x[2] - C4*x[4] + C2*x[6] + RND;
    ev[3] = C4*x[0] - C2*x[2] + C4*x[4] - C6*x[6] + RND;
    od[0] = C1*x[1] + C3*x[3] + C5*x[5] + C7*x[7];
    od[1] = C3*x[1] - C7*x[3] - C1*x[5] - C5*x[7];
    od[2] = C5*x[1] - C1*x[3] + C7*x[5] + C3*x[7];
    od[3] = C7*x[1] - C5*x[3] + C3*x[5] - C1*x[7];
  end

  generate
    for (gi = 0; gi < HALF; gi++) begin : g_bfly
      logic signed [ACC_W-1:0] s_hi;
      logic signed [ACC_W-1:0] s_lo;
      assign s_hi = (ev[gi] + od[gi]) >>> SHIFT;
      assign s_lo = (ev[gi] - od[gi]) >>> SHIFT;
      assign lane[gi]         = s_hi[CW-1:0];
      assign lane[NPT-1-gi]   = s_lo[CW-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPT; i++) res[i] <= '0;
    end else if (load) begin
      for (int i = 0; i < NPT; i++) res[i] <= lane[i];
    end
  end
endmodule

// File: rtl/idctc_clip.sv
`timescale 1ns/1ps
module idctc_clip #(
  parameter int CW    = 16,
  parameter int PIX_W = 8
) (
  input  logic signed [CW-1:0] val,
  input  logic [PIX_W-1:0]     pred,
  input  logic                 add_en,
  output logic [PIX_W-1:0]     pix
);
  localparam int SW = CW + 2;
  localparam logic signed [SW-1:0] PMAX = SW'((1 << PIX_W) - 1);

  logic signed [SW-1:0] pext;
  logic signed [SW-1:0] sum;

  assign pext = add_en ? $signed({{(SW-PIX_W){1'b0}}, pred}) : '0;

  always_comb begin
    sum = SW'(val) + pext;
    if (sum < 0)          pix = '0;
    else if (sum > PMAX)  pix = '1;
    else                  pix = sum[PIX_W-1:0];
  end
endmodule

// File: rtl/idctc_column.sv
`timescale 1ns/1ps
module idctc_column #(
  parameter int CW     = 16,
  parameter int PIX_W  = 8,
  parameter int ADDR_W = 12,
  parameter int SHIFT  = 20
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            start,
  input  logic [1:0]                      mode,
  input  logic [idctc_pkg::NPT*CW-1:0]    coef_i,
  input  logic [ADDR_W-1:0]               base_addr,
  input  logic [ADDR_W-1:0]               stride,
  output logic                            done,
  output logic [idctc_pkg::NPT*CW-1:0]    raw_res,
  output logic                            mem_req,
  output logic                            mem_we,
  output logic [ADDR_W-1:0]               mem_addr,
  output logic [PIX_W-1:0]                mem_wdata,
  input  logic                            mem_gnt,
  input  logic [PIX_W-1:0]                mem_rdata
);
  import idctc_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NPT - 1);

  state_t               st;
  logic [IDX_W-1:0]     idx;
  logic [IDX_W-1:0]     sel_idx;
  logic [1:0]           jmode;
  logic [ADDR_W-1:0]    base_q;
  logic [ADDR_W-1:0]    stride_q;
  logic signed [CW-1:0] cap [NPT];
  logic signed [CW-1:0] res [NPT];
  logic [PIX_W-1:0]     clip_pix;
  logic                 job_raw;
  logic                 job_put;

  assign job_raw = (jmode == MODE_RAW);
  assign job_put = (jmode == MODE_PUT);

  idctc_core #(.CW(CW), .SHIFT(SHIFT)) u_core (
    .clk  (clk),
    .rst  (rst),
    .load (st == S_CALC),
    .coef (cap),
    .res  (res)
  );

  // in a transfer the next pixel is prepared; otherwise the current one
  assign sel_idx = (st == S_XFER) ? idx + IDX_W'(1) : idx;

  idctc_clip #(.CW(CW), .PIX_W(PIX_W)) u_clip (
    .val    (res[sel_idx]),
    .pred   (mem_rdata),
    .add_en (st == S_RWAIT),
    .pix    (clip_pix)
  );

  genvar gk;
  generate
    for (gk = 0; gk < NPT; gk++) begin : g_raw
      assign raw_res[gk*CW +: CW] = res[gk];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      idx       <= '0;
      jmode     <= MODE_RAW;
      base_q    <= '0;
      stride_q  <= '0;
      done      <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      for (int i = 0; i < NPT; i++) cap[i] <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (start) begin
            jmode    <= mode;
            base_q   <= base_addr;
            stride_q <= stride;
            idx      <= '0;
            for (int i = 0; i < NPT; i++) cap[i] <= coef_i[i*CW +: CW];
            st       <= S_CALC;
          end
        end
        S_CALC: st <= S_ISSUE;
        S_ISSUE: begin
          if (job_raw) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            mem_req   <= 1'b1;
            mem_we    <= job_put;
            mem_addr  <= base_q;
            mem_wdata <= clip_pix;
            st        <= S_XFER;
          end
        end
        S_XFER: begin
          if (mem_gnt) begin
            if (mem_we) begin
              if (idx == LAST) begin
                mem_req <= 1'b0;
                mem_we  <= 1'b0;
                done    <= 1'b1;
                st      <= S_IDLE;
              end else begin
                idx      <= idx + IDX_W'(1);
                mem_addr <= mem_addr + stride_q;
                if (job_put) mem_wdata <= clip_pix;
                else         mem_we    <= 1'b0;
              end
            end else begin
              mem_req <= 1'b0;
              st      <= S_RWAIT;
            end
          end
        end
        S_RWAIT: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_wdata <= clip_pix;
          st        <= S_XFER;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    done && !job_raw |-> $past(mem_req && mem_gnt && mem_we));

  // R3
  raw_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
    job_raw && st != S_IDLE |-> !mem_req);

  // R4
  put_write_only_chk: assert property (@(posedge clk) disable iff (rst)
    job_put && mem_req |-> mem_we);

  // R5
  read_then_write_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_gnt && !mem_we |=> !mem_req ##1 (mem_req && mem_we && mem_addr == $past(mem_addr, 2)));

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    start && st != S_IDLE |=> $stable(jmode) && $stable(base_q) && $stable(stride_q));
endmodule

// File: tb/tb_idctc_column.sv
`timescale 1ns/1ps
module tb_idctc_column;
  localparam int CW = 16;
  localparam int PIX_W = 8;
  localparam int ADDR_W = 12;
  localparam int MSZ = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [8*CW-1:0] coef_i = '0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic [ADDR_W-1:0] stride = '0;
  logic done;
  logic [8*CW-1:0] raw_res;
  logic mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [PIX_W-1:0] mem_wdata;
  logic mem_gnt = 1'b0;
  logic [PIX_W-1:0] mem_rdata = '0;

  always #10 clk = ~clk;

  idctc_column #(.CW(CW), .PIX_W(PIX_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .coef_i(coef_i),
    .base_addr(base_addr), .stride(stride), .done(done), .raw_res(raw_res),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );

  typedef struct packed { logic we; int addr; int data; } txn_t;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [7:0] mem_m [0:MSZ-1];
  txn_t q[$];
  longint cx [8];
  longint ey [8];
  bit m_busy = 0;
  bit m_raw = 0;
  int raw_cd = 0;
  bit done_nxt = 0;
  bit p_pend = 0;
  logic p_we;
  logic [ADDR_W-1:0] p_addr;
  logic [PIX_W-1:0] p_wdata;
  int g_mode = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clamp8(input longint v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return int'(v);
  endfunction

  // R2 reference arithmetic
  function automatic void calc_ey();
    longint a [4];
    longint b [4];
    longint rnd;
    rnd = longint'(1) << 19;
    a[0] = 16383*cx[0] + 21407*cx[2] + 16383*cx[4] + 8867*cx[6] + rnd;
    a[1] = 16383*cx[0] + 8867*cx[2] - 16383*cx[4] - 21407*cx[6] + rnd;
    a[2] = 16383*cx[0] - 8867*cx[2] - 16383*cx[4] + 21407*cx[6] + rnd;
    a[3] = 16383*cx[0] - 21407*cx[2] + 16383*cx[4] - 8867*cx[6] + rnd;
    b[0] = 22725*cx[1] + 19266*cx[3] + 12873*cx[5] + 4520*cx[7];
    b[1] = 19266*cx[1] - 4520*cx[3] - 22725*cx[5] - 12873*cx[7];
    b[2] = 12873*cx[1] - 22725*cx[3] + 4520*cx[5] + 19266*cx[7];
    b[3] = 4520*cx[1] - 12873*cx[3] + 19266*cx[5] - 22725*cx[7];
    for (int k = 0; k < 4; k++) begin
      ey[k]     = (a[k] + b[k]) >>> 20;
      ey[7 - k] = (a[k] - b[k]) >>> 20;
    end
  endfunction

  // cycle model and checker, evaluated away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst) begin
        mem_gnt = 1'b0; m_busy = 0; raw_cd = 0; done_nxt = 0; p_pend = 0;
        q.delete();
      end else begin
        bit exp_d;
        exp_d = 0;
        if (raw_cd > 0) begin
          raw_cd--;
          if (raw_cd == 0) exp_d = 1;
        end
        if (done_nxt) begin exp_d = 1; done_nxt = 0; end
        chk(done == exp_d, "R7 done timing", longint'(done), longint'(exp_d));
        if (exp_d) begin
          m_busy = 0;
          if (m_raw) begin
            for (int k = 0; k < 8; k++)
              chk(raw_res[k*CW +: CW] == CW'(ey[k]), "R3 raw result",
                  longint'($signed(raw_res[k*CW +: CW])), ey[k]);
          end
        end
        if (start && !m_busy) begin
          int b, s, ad;
          m_busy = 1;
          for (int k = 0; k < 8; k++) cx[k] = longint'($signed(coef_i[k*CW +: CW]));
          calc_ey();
          b = int'(base_addr); s = int'(stride);
          m_raw = (mode == 2'b00);
          q.delete();
          if (m_raw) raw_cd = 3;
          for (int k = 0; k < 8 && !m_raw; k++) begin
            ad = (b + k*s) % MSZ;
            if (mode == 2'b01) begin
              q.push_back('{we: 1'b1, addr: ad, data: clamp8(ey[k])});
            end else begin
              q.push_back('{we: 1'b0, addr: ad, data: 0});
              q.push_back('{we: 1'b1, addr: ad, data: clamp8(longint'(mem_m[ad]) + ey[k])});
            end
          end
        end
        if (p_pend)
          chk(mem_req && mem_we == p_we && mem_addr == p_addr && mem_wdata == p_wdata,
              "R6 request held", longint'(mem_addr), longint'(p_addr));
        mem_gnt = (g_mode == 1) ? 1'b1 : lf[0];
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (mem_req && q.size() == 0) begin
          chk(0, "R3 unexpected request", longint'(mem_addr), -1);
        end else if (mem_req && mem_gnt) begin
          txn_t t;
          t = q.pop_front();
          chk(mem_we == t.we, "R5 access kind", longint'(mem_we), longint'(t.we));
          chk(int'(mem_addr) == t.addr, "R4 address", longint'(mem_addr), longint'(t.addr));
          if (t.we) begin
            chk(int'(mem_wdata) == t.data, "R4 R5 pixel data", longint'(mem_wdata), longint'(t.data));
            mem_m[int'(mem_addr)] = mem_wdata;
            if (q.size() == 0) done_nxt = 1;
          end else begin
            mem_rdata = mem_m[int'(mem_addr)];
          end
        end
        p_pend = mem_req && !mem_gnt;
        p_we = mem_we; p_addr = mem_addr; p_wdata = mem_wdata;
      end
    end
  end

  task automatic drive(input logic [1:0] m, input int b, input int s,
                       input int a0, input int a1, input int a2, input int a3,
                       input int a4, input int a5, input int a6, input int a7);
    mode = m;
    base_addr = ADDR_W'(b);
    stride = ADDR_W'(s);
    coef_i = {16'(a7), 16'(a6), 16'(a5), 16'(a4), 16'(a3), 16'(a2), 16'(a1), 16'(a0)};
    start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic wait_idle();
    do begin @(posedge clk); #2; end while (m_busy);
    @(posedge clk); #2;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < MSZ; i++) mem_m[i] = 8'((i*37 + 11) & 255);
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(mem_req == 1'b0, "R1 mem_req after reset", longint'(mem_req), 0);
    chk(done == 1'b0, "R1 done after reset", longint'(done), 0);
    @(posedge clk); #2;

    // R3 raw mode, mixed and extreme inputs
    drive(2'b00, 0, 1, 2000, -1500, 800, -600, 400, 300, -200, 100); wait_idle();
    drive(2'b00, 0, 1, 32767, -32768, 32767, -32768, 32767, -32768, 32767, -32768); wait_idle();
    // R4 put: DC, high saturation, low saturation, mixed with odd stride
    drive(2'b01, 0, 1, 1024, 0, 0, 0, 0, 0, 0, 0); wait_idle();
    drive(2'b01, 100, 16, 32767, 0, 0, 0, 0, 0, 0, 0); wait_idle();
    drive(2'b01, 300, 3, -20000, 0, 0, 0, 0, 0, 0, 0); wait_idle();
    drive(2'b01, 900, 9, 9000, -4000, 3000, 2500, -1200, 800, -700, 300); wait_idle();
    // R5 add with varied predictions and both saturation ends
    drive(2'b10, 1200, 7, 3000, 1500, -2500, 900, 600, -400, 350, -150); wait_idle();
    for (int k = 0; k < 8; k++) mem_m[500 + 2*k] = 8'd250;
    drive(2'b11, 500, 2, 4000, 0, 0, 0, 0, 0, 0, 0); wait_idle();
    for (int k = 0; k < 8; k++) mem_m[700 + k] = 8'd3;
    drive(2'b10, 700, 1, -4000, 0, 0, 0, 0, 0, 0, 0); wait_idle();

    // R6 grant held high: transfers back to back
    g_mode = 1;
    drive(2'b01, 1500, 5, 6000, 2000, -1000, 500, 250, -125, 60, -30); wait_idle();
    drive(2'b10, 1700, 11, -3000, 1000, 2000, -800, 400, 200, -100, 50); wait_idle();
    g_mode = 0;

    // R8 start during a running column is ignored
    drive(2'b01, 2000, 4, 5000, 1000, 0, 0, 0, 0, 0, 0);
    repeat (4) begin @(posedge clk); #2; end
    drive(2'b00, 2500, 1, -9000, 0, 0, 0, 0, 0, 0, 0);
    wait_idle();

    // R8 start in the cycle done is high is accepted
    drive(2'b01, 2600, 2, 7000, -500, 0, 0, 0, 0, 0, 0);
    do begin @(posedge clk); #2; end while (!done);
    drive(2'b10, 2800, 3, -2000, 700, 0, 300, 0, 0, 0, 0);
    wait_idle();
    drive(2'b00, 0, 1, 1234, -2345, 3456, -4567, 5678, -6789, 7890, -8901); wait_idle();

    chk(q.size() == 0, "R4 all transfers seen", longint'(q.size()), 0);
    summary();
  end
endmodule